// File: doc/BRIEF.md
# Predicated Execute-Entry Gate with Branch Flush Tracking

This unit sits where a micro-op leaves the second decode stage (ID2) and enters the first execute stage (EX1) of an in-order pipeline. It decides whether that op runs. The decision uses three inputs: the ID2 flush bit it keeps, the op's two-bit predicate mode, and the status T flag. An op that may not run reaches EX1 as a harmless NOP. A branch that is disabled by its predicate becomes a NO_BRANCH marker. This lets a branch that was wrongly predicted taken still steer fetch back to the fall-through address.

The unit owns the flush mask for the front stages (IF, ID1, ID2). The mask moves one stage per cycle. The branch predictor can set the IF bit. A redirect raised by the branch in EX1 sets every front bit at once.

The op enters through a valid/ready pair. `id2_ready` drops for one cycle when a predicated op in ID2 must wait for the op in EX1 to write T. While `id2_ready` is low, the source must hold its op and its predicate unchanged. During that cycle a bubble goes into EX1 and the flush mask holds. The EX1 side has no back-pressure: EX1 always advances.

Top module: `pred_flush_gate`

## Requirements
- R1: The predicate mode `id2_pred` decides whether an unflushed op runs:
  - 2'b00 means always.
  - 2'b01 means never.
  - 2'b10 means run when T is 1.
  - 2'b11 means run when T is 0.
- R2: When the ID2 flush bit (`stage_flush[2]`) is set, the op reaches EX1 with opcode NOP (6'h00) and `ex1_is_branch` low, whatever its predicate mode.
- R3: An op disabled by its predicate and not flushed is rewritten as follows:
  - A non-branch becomes NOP (6'h00).
  - A branch becomes NO_BRANCH (6'h3F) and keeps `ex1_is_branch` high.
  - An enabled op reaches EX1 unchanged.
- R4: A valid branch in EX1 redirects fetch in two cases:
  - With any opcode other than NO_BRANCH and no taken prediction, it redirects to its target (`redirect_to_target`=1).
  - As NO_BRANCH with a taken prediction, it redirects to the fall-through address (`redirect_to_target`=0).
  - In every other case there is no redirect.
- R5: The flush mask `stage_flush` has bit 0 for IF, bit 1 for ID1 and bit 2 for ID2. Each cycle the IF bit loads `bp_flush_if`, and the ID1 and ID2 bits take the bit of the stage before them.
- R6: In a cycle where `redirect` is high, the IF, ID1 and ID2 ops count as flushed. The ID2 op entering EX1 becomes NOP, and on the next cycle `stage_flush` reads 3'b110.
- R7: `id2_ready` is low exactly when all of the following hold:
  - `id2_valid` is high and `id2_pred` is not 2'b00.
  - A valid EX1 op has `ex1_writes_t` set.
  - `redirect` is low.
- R8: While `id2_ready` is low, the next EX1 slot is a bubble (`ex1_valid`=0) and `stage_flush` keeps its value, including the IF bit.
- R9: A gated op never carries `ex1_writes_t`. A gated T-writer in EX1 therefore never stalls a predicated op behind it.
- R10: After reset, `ex1_valid` is 0, `stage_flush` is 3'b000 and `redirect` is 0.
- R11: When `id2_valid` is 0 and the unit is not stalled, the next EX1 slot is a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id2_valid | input | 1 | An op is present in ID2 |
| id2_ready | output | 1 | The ID2 op is accepted this cycle (low during a T-hazard stall) |
| id2_opcode | input | 6 | Opcode of the ID2 op |
| id2_is_branch | input | 1 | The ID2 op is a branch |
| id2_writes_t | input | 1 | The ID2 op will update T |
| id2_pred_taken | input | 1 | The predictor predicted this branch taken |
| id2_pred | input | 2 | Predicate mode |
| t_flag | input | 1 | Current status T flag |
| bp_flush_if | input | 1 | The predictor marks the IF op as flushed |
| stage_flush | output | 3 | Flush bits for IF, ID1, ID2 |
| ex1_valid | output | 1 | The EX1 slot holds an op |
| ex1_opcode | output | 6 | Opcode in EX1 after gating |
| ex1_is_branch | output | 1 | The EX1 op is a branch |
| ex1_writes_t | output | 1 | The EX1 op will update T |
| ex1_pred_taken | output | 1 | Taken prediction carried with the EX1 op |
| redirect | output | 1 | The EX1 branch redirects fetch |
| redirect_to_target | output | 1 | 1 selects the branch target, 0 the fall-through address |

## Verification
Several behaviours are checked by the assertions on every cycle:
- A flushed ID2 op lands as NOP, and a never-mode op lands as NOP or NO_BRANCH.
- A stall gives a bubble and a frozen mask.
- The mask shifts when there is no stall.
- A redirect is followed by 3'b110 and never coincides with a stall.
- A NOP in EX1 never carries a T write.

Only the bench scenarios can show the following:
- The full predicate-by-T table and the exact rewritten opcodes.
- The two redirect directions.
- The predictor bit travelling IF to ID2 across three cycles.
- That a redirect takes priority over a pending T hazard.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int OPC_W = 6;

  typedef enum logic [1:0] {
    PM_ALWAYS = 2'b00,
    PM_NEVER  = 2'b01,
    PM_IF_T   = 2'b10,
    PM_IF_NT  = 2'b11
  } pred_mode_e;

  typedef struct packed {
    logic [OPC_W-1:0] opcode;
    logic             is_branch;
    logic             writes_t;
    logic             pred_taken;
  } uop_t;
endpackage

// File: rtl/pfg_enable.sv
module pfg_enable
  import pfg_pkg::*;
(
  input  logic       flushed,
  input  logic [1:0] pred,
  input  logic       t_flag,
  output logic       enable
);
  pred_mode_e mode;
  logic       pred_ok;

  always_comb begin
    mode = pred_mode_e'(pred);
    unique case (mode)
      PM_ALWAYS: pred_ok = 1'b1;
      PM_NEVER:  pred_ok = 1'b0;
      PM_IF_T:   pred_ok = t_flag;
      PM_IF_NT:  pred_ok = ~t_flag;
      default:   pred_ok = 1'b0;
    endcase
    enable = pred_ok & ~flushed;
  end
endmodule

// File: rtl/pfg_flush_mask.sv
module pfg_flush_mask #(
  parameter int N_FRONT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic               redirect,
  input  logic               bp_set_if,
  output logic [N_FRONT-1:0] mask,
  output logic               last_eff
);
  logic [N_FRONT-1:0] eff;
  logic [N_FRONT-1:0] nxt;

  assign eff      = mask | {N_FRONT{redirect}};
  assign last_eff = eff[N_FRONT-1];

  assign nxt[0] = bp_set_if & ~redirect;
  for (genvar g = 1; g < N_FRONT; g++) begin : g_shift
    assign nxt[g] = eff[g-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    mask <= '0;
    else if (!hold) mask <= nxt;
  end
endmodule

// File: rtl/pfg_hazard.sv
module pfg_hazard (
  input  logic       id2_valid,
  input  logic [1:0] id2_pred,
  input  logic       ex1_valid,
  input  logic       ex1_writes_t,
  input  logic       redirect,
  output logic       stall
);
  logic predicated;
  assign predicated = id2_pred != 2'b00;
  assign stall = id2_valid & predicated & ex1_valid & ex1_writes_t & ~redirect;
endmodule

// File: rtl/pred_flush_gate.sv
module pred_flush_gate
  import pfg_pkg::*;
#(
  parameter int               N_FRONT  = 3,
  parameter logic [OPC_W-1:0] NOP_OPC  = 6'h00,
  parameter logic [OPC_W-1:0] NOBR_OPC = 6'h3F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               id2_valid,
  output logic               id2_ready,
  input  logic [OPC_W-1:0]   id2_opcode,
  input  logic               id2_is_branch,
  input  logic               id2_writes_t,
  input  logic               id2_pred_taken,
  input  logic [1:0]         id2_pred,
  input  logic               t_flag,
  input  logic               bp_flush_if,
  output logic [N_FRONT-1:0] stage_flush,
  output logic               ex1_valid,
  output logic [OPC_W-1:0]   ex1_opcode,
  output logic               ex1_is_branch,
  output logic               ex1_writes_t,
  output logic               ex1_pred_taken,
  output logic               redirect,
  output logic               redirect_to_target
);
  uop_t in_op, gated_op, ex1_q;
  logic ex1_vq;
  logic id2_flushed, enable, stall;

  assign in_op = '{opcode: id2_opcode, is_branch: id2_is_branch,
                   writes_t: id2_writes_t, pred_taken: id2_pred_taken};

  // Redirect decision for the op already in EX1
  always_comb begin
    redirect           = 1'b0;
    redirect_to_target = 1'b0;
    if (ex1_vq && ex1_q.is_branch) begin
      if (ex1_q.opcode == NOBR_OPC) begin
        redirect = ex1_q.pred_taken;
      end else begin
        redirect           = ~ex1_q.pred_taken;
        redirect_to_target = ~ex1_q.pred_taken;
      end
    end
  end

  pfg_hazard u_hazard (
    .id2_valid    (id2_valid),
    .id2_pred     (id2_pred),
    .ex1_valid    (ex1_vq),
    .ex1_writes_t (ex1_q.writes_t),
    .redirect     (redirect),
    .stall        (stall)
  );

  pfg_flush_mask #(.N_FRONT(N_FRONT)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (stall),
    .redirect  (redirect),
    .bp_set_if (bp_flush_if),
    .mask      (stage_flush),
    .last_eff  (id2_flushed)
  );

  pfg_enable u_enable (
    .flushed (id2_flushed),
    .pred    (id2_pred),
    .t_flag  (t_flag),
    .enable  (enable)
  );

  // Rewrite of a disabled op
  always_comb begin
    gated_op = in_op;
    if (!enable) begin
      gated_op.writes_t = 1'b0;
      if (in_op.is_branch && !id2_flushed) begin
        gated_op.opcode = NOBR_OPC;
      end else begin
        gated_op.opcode    = NOP_OPC;
        gated_op.is_branch = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex1_vq <= 1'b0;
      ex1_q  <= '0;
    end else if (stall || !id2_valid) begin
      ex1_vq <= 1'b0;
      ex1_q  <= '0;
    end else begin
      ex1_vq <= 1'b1;
      ex1_q  <= gated_op;
    end
  end

  assign id2_ready      = ~stall;
  assign ex1_valid      = ex1_vq;
  assign ex1_opcode     = ex1_q.opcode;
  assign ex1_is_branch  = ex1_q.is_branch;
  assign ex1_writes_t   = ex1_q.writes_t;
  assign ex1_pred_taken = ex1_q.pred_taken;
endmodule

// File: rtl/pred_flush_gate_chk.sv
module pred_flush_gate_chk #(
  parameter int         N_FRONT  = 3,
  parameter logic [5:0] NOP_OPC  = 6'h00,
  parameter logic [5:0] NOBR_OPC = 6'h3F
) (
  input logic               clk,
  input logic               rst_n,
  input logic               id2_valid,
  input logic               id2_ready,
  input logic [1:0]         id2_pred,
  input logic [N_FRONT-1:0] stage_flush,
  input logic               ex1_valid,
  input logic [5:0]         ex1_opcode,
  input logic               ex1_is_branch,
  input logic               ex1_writes_t,
  input logic               redirect
);
  p_flush_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (id2_valid && id2_ready && stage_flush[N_FRONT-1])
      |=> (ex1_valid && ex1_opcode == NOP_OPC && !ex1_is_branch));

  p_never_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (id2_valid && id2_ready && id2_pred == 2'b01)
      |=> (ex1_opcode == NOP_OPC || ex1_opcode == NOBR_OPC));

  p_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !id2_ready |=> !ex1_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !id2_ready |=> $stable(stage_flush));

  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (id2_ready && !redirect)
      |=> stage_flush[N_FRONT-1] == $past(stage_flush[N_FRONT-2]));

  p_redirect_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (stage_flush[N_FRONT-1:1] == '1 && !stage_flush[0]));

  p_redirect_no_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> id2_ready);

  p_nop_no_t_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ex1_valid && ex1_opcode == NOP_OPC) |-> !ex1_writes_t);
endmodule

bind pred_flush_gate pred_flush_gate_chk #(
  .N_FRONT(N_FRONT), .NOP_OPC(NOP_OPC), .NOBR_OPC(NOBR_OPC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .id2_valid(id2_valid), .id2_ready(id2_ready),
  .id2_pred(id2_pred), .stage_flush(stage_flush), .ex1_valid(ex1_valid),
  .ex1_opcode(ex1_opcode), .ex1_is_branch(ex1_is_branch),
  .ex1_writes_t(ex1_writes_t), .redirect(redirect)
);

// File: tb/pred_flush_gate_bench.sv
module pred_flush_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       id2_valid = 1'b0, id2_is_branch = 1'b0, id2_writes_t = 1'b0;
  logic       id2_pred_taken = 1'b0, t_flag = 1'b0, bp_flush_if = 1'b0;
  logic [5:0] id2_opcode = 6'h00;
  logic [1:0] id2_pred = 2'b00;
  logic       id2_ready, ex1_valid, ex1_is_branch, ex1_writes_t, ex1_pred_taken;
  logic       redirect, redirect_to_target;
  logic [5:0] ex1_opcode;
  logic [2:0] stage_flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pred_flush_gate u_pred_flush_gate (
    .clk(clk), .rst_n(rst_n), .id2_valid(id2_valid), .id2_ready(id2_ready),
    .id2_opcode(id2_opcode), .id2_is_branch(id2_is_branch),
    .id2_writes_t(id2_writes_t), .id2_pred_taken(id2_pred_taken),
    .id2_pred(id2_pred), .t_flag(t_flag), .bp_flush_if(bp_flush_if),
    .stage_flush(stage_flush), .ex1_valid(ex1_valid), .ex1_opcode(ex1_opcode),
    .ex1_is_branch(ex1_is_branch), .ex1_writes_t(ex1_writes_t),
    .ex1_pred_taken(ex1_pred_taken), .redirect(redirect),
    .redirect_to_target(redirect_to_target)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] p, input logic t,
                       input logic br, input logic wt, input logic ptk,
                       input logic [5:0] opc, input logic bp);
    @(negedge clk);
    id2_valid = v; id2_pred = p; t_flag = t; id2_is_branch = br;
    id2_writes_t = wt; id2_pred_taken = ptk; id2_opcode = opc; bp_flush_if = bp;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // pred, t, br, ptk, opcode, expected opcode, expected branch marker
  localparam int NV = 9;
  localparam logic [NV-1:0][17:0] VEC = {
    {2'b01, 1'b0, 1'b1, 1'b0, 6'h31, 6'h3F, 1'b1},
    {2'b11, 1'b0, 1'b1, 1'b1, 6'h30, 6'h30, 1'b1},
    {2'b10, 1'b0, 1'b1, 1'b0, 6'h30, 6'h3F, 1'b1},
    {2'b11, 1'b1, 1'b0, 1'b0, 6'h21, 6'h00, 1'b0},
    {2'b11, 1'b0, 1'b0, 1'b0, 6'h21, 6'h21, 1'b0},
    {2'b10, 1'b0, 1'b0, 1'b0, 6'h05, 6'h00, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b0, 6'h05, 6'h05, 1'b0},
    {2'b01, 1'b1, 1'b0, 1'b0, 6'h12, 6'h00, 1'b0},
    {2'b00, 1'b0, 1'b0, 1'b0, 6'h12, 6'h12, 1'b0}
  };

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 ex1_valid", ex1_valid, 0);
    chk("R10 stage_flush", stage_flush, 0);
    chk("R10 redirect", redirect, 0);
    @(negedge clk); rst_n = 1'b1;

    // Table walk: R1 / R3
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][17:16], VEC[i][15], VEC[i][14], 1'b0, VEC[i][13],
            VEC[i][12:7], 1'b0);
      tick();
      chk("R1/R3 opcode", ex1_opcode, VEC[i][6:1]);
      chk("R3 branch marker", ex1_is_branch, VEC[i][0]);
      chk("R4 no redirect", redirect, 0);
    end

    // R11: no op gives a bubble
    drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 6'h12, 1'b0);
    tick();
    chk("R11 bubble", ex1_valid, 0);

    // R5 + R2: predictor bit walks through the front stages
    drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b1);
    tick();
    chk("R5 IF bit", stage_flush, 3'b001);
    drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0);
    tick();
    chk("R5 ID1 bit", stage_flush, 3'b010);
    drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0);
    tick();
    chk("R5 ID2 bit", stage_flush, 3'b100);
    drive(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 6'h30, 1'b0);
    tick();
    chk("R2 flushed opcode", ex1_opcode, 6'h00);
    chk("R2 flushed branch marker", ex1_is_branch, 0);
    chk("R2 no redirect", redirect, 0);
    chk("R5 mask cleared", stage_flush, 3'b000);

    // R8/R7: T hazard stall, mask holds including IF bit
    drive(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 6'h11, 1'b0);
    tick();
    chk("R7 T writer in EX1", ex1_writes_t, 1);
    drive(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 6'h05, 1'b1);
    chk("R7 stall raised", id2_ready, 0);
    tick();
    chk("R8 bubble", ex1_valid, 0);
    chk("R8 mask held", stage_flush, 3'b000);
    drive(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 6'h05, 1'b0);
    chk("R7 stall released", id2_ready, 1);
    tick();
    chk("R8 held op enters", ex1_opcode, 6'h05);

    // R9: gated T writer does not stall
    drive(1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 6'h11, 1'b0);
    tick();
    chk("R9 gated writes_t", ex1_writes_t, 0);
    drive(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 6'h05, 1'b0);
    chk("R9 no stall", id2_ready, 1);
    tick();

    // R4/R6/R7: taken-to-target redirect overrides hazard
    drive(1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 6'h30, 1'b0);
    tick();
    drive(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 6'h05, 1'b1);
    chk("R4 redirect", redirect, 1);
    chk("R4 to target", redirect_to_target, 1);
    chk("R7 redirect overrides stall", id2_ready, 1);
    tick();
    chk("R6 ID2 op flushed", ex1_opcode, 6'h00);
    chk("R6 mask after redirect", stage_flush, 3'b110);
    drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0);
    tick();
    chk("R6 mask drains", stage_flush, 3'b100);
    tick();
    chk("R6 mask empty", stage_flush, 3'b000);

    // R4: NO_BRANCH with taken prediction returns to fall-through
    drive(1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 6'h30, 1'b0);
    tick();
    chk("R3 NO_BRANCH", ex1_opcode, 6'h3F);
    chk("R4 fall-through redirect", redirect, 1);
    chk("R4 fall-through select", redirect_to_target, 0);
    drive(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0);
    tick();
    chk("R6 mask after NO_BRANCH redirect", stage_flush, 3'b110);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule